// File: doc/BRIEF.md
# Interval Down-Counter Timer

This block is a bus-attached 32-bit interval timer. Software writes a reload value into the period register, which also loads the live counter at once. It then writes the control word. Two bits of that word act as strobes: one starts the counter and one stops it. The other two bits are stored settings, one for interrupt enable and one for auto-reload. While the counter runs it counts down by one on each clock. When it reaches zero the timeout flag is set. In one-shot mode the counter then halts. In continuous mode it reloads from the period register and keeps counting.

Software can read the live count at any time through a read-only snapshot word. A write of any data to the status word acknowledges the timeout. The interrupt line is a level. It stays high while the timeout flag is set and interrupts are enabled.

The register port is a plain single-cycle interface. Writes take effect on the clock edge where select and write-enable are both high. Read data is combinational from the address and the current state. The reset input is asserted asynchronously and released synchronously inside the block, two clock edges after it is deasserted.

Top module: `interval_timer`

## Requirements
- R1: While reset is active, and after it is released, every readable word reads zero, the counter is stopped and the interrupt output is low.
- R2: Address bits [3:2] pick the word: 0x00 status, 0x04 control, 0x08 period, 0x0C snapshot. An access whose address has any bit above bit 3 set reads zero and changes nothing.
- R3: A control write stores the full data word, and the stored value reads back unchanged. Bit 0 is interrupt enable, bit 1 is continuous mode, bit 2 is start and bit 3 is stop. A write with the start bit set sets the running flag, which is status bit 1.
- R4: A control write with the stop bit set clears the running flag and freezes the count. When start and stop are both set in one write, stop wins.
- R5: A period write stores the value and loads it into the counter on the same edge. While the counter is stopped its value does not change.
- R6: While running with count P ≥ 1, the count drops by one per clock. The timeout flag (status bit 0) sets on the P-th rising edge after the start edge.
- R7: In one-shot mode (bit 1 clear), expiry clears the running flag and the count stays at zero.
- R8: In continuous mode, expiry reloads the count from the period register and the counter keeps running, so the flag is raised again every P clocks.
- R9: A status write clears the timeout flag whatever data it carries.
- R10: The interrupt output is high exactly when the timeout flag and the interrupt-enable bit are both set. It follows changes to either one without waiting for another expiry.
- R11: A write to the snapshot word changes neither the count nor any other register.
- R12: If an expiry and a status write land on the same edge, the timeout flag ends up set.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_sel | input | 1 | Access valid this cycle |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W (5) | Byte address |
| bus_wdata | input | DATA_W (32) | Write data |
| bus_rdata | output | DATA_W (32) | Read data, combinational; zero when not reading a mapped word |
| irq | output | 1 | Level interrupt |

## Verification
The hardest case to reach is the race between an acknowledge and a fresh expiry on the same edge (R12). Doing it wrongly loses an event, and software would never see the second timeout. The bench starts a one-shot count of known length. It then counts falling edges from the start write so that its status write lands exactly on the expiry edge. After that it checks that the flag survived. A second timed sequence stops a continuous count just after it reloads, which shows that the stop takes effect on a running counter.

// File: rtl/interval_timer_pkg.sv
package interval_timer_pkg;

  typedef enum logic [1:0] {
    IDX_STAT = 2'd0,
    IDX_CTRL = 2'd1,
    IDX_PER  = 2'd2,
    IDX_SNAP = 2'd3
  } reg_idx_e;

  localparam int CTL_IE    = 0;
  localparam int CTL_CONT  = 1;
  localparam int CTL_START = 2;
  localparam int CTL_STOP  = 3;

  localparam int STS_TO  = 0;
  localparam int STS_RUN = 1;

  localparam int IDX_LSB = 2;
  localparam int IDX_W   = 2;

endpackage

// File: rtl/itmr_rst_sync.sv
module itmr_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);

  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= 2'b00;
    else        sync_q <= {sync_q[0], 1'b1};
  end

  assign rst_sync_n = sync_q[1];

endmodule

// File: rtl/itmr_regs.sv
module itmr_regs
  import interval_timer_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_stat,
  input  logic              wr_ctrl,
  input  logic              wr_per,
  input  logic [DATA_W-1:0] wdata,
  input  logic              expire,
  output logic [DATA_W-1:0] ctrl_q,
  output logic [DATA_W-1:0] period_q,
  output logic              to_q,
  output logic              run_q
);

  logic to_d;
  logic run_d;

  // flag: a new expiry beats an acknowledge on the same edge
  always_comb begin
    to_d = expire | (to_q & ~wr_stat);
  end

  // running: stop strobe first, then start, then one-shot expiry
  always_comb begin
    run_d = run_q;
    if (wr_ctrl && wdata[CTL_STOP])       run_d = 1'b0;
    else if (wr_ctrl && wdata[CTL_START]) run_d = 1'b1;
    else if (expire && !ctrl_q[CTL_CONT]) run_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q   <= '0;
      period_q <= '0;
      to_q     <= 1'b0;
      run_q    <= 1'b0;
    end else begin
      if (wr_ctrl) ctrl_q   <= wdata;
      if (wr_per)  period_q <= wdata;
      to_q  <= to_d;
      run_q <= run_d;
    end
  end

endmodule

// File: rtl/itmr_count.sv
module itmr_count #(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              run,
  input  logic              cont,
  input  logic              load_en,
  input  logic [DATA_W-1:0] load_val,
  input  logic [DATA_W-1:0] period,
  output logic [DATA_W-1:0] count,
  output logic              expire
);

  logic [DATA_W-1:0] cnt_q;
  logic [DATA_W-1:0] cnt_d;
  logic              cnt_en;

  // expiry on the edge where the count steps to zero (or already sits there)
  assign expire = run && (cnt_q[DATA_W-1:1] == '0);
  assign cnt_en = load_en | run;

  always_comb begin
    cnt_d = cnt_q;
    if (load_en)     cnt_d = load_val;
    else if (expire) cnt_d = cont ? period : '0;
    else if (run)    cnt_d = cnt_q - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  assign count = cnt_q;

endmodule

// File: rtl/interval_timer.sv
module interval_timer
  import interval_timer_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int ADDR_W = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_sel,
  input  logic              bus_we,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  output logic              irq
);

  localparam int HIGH_LSB = IDX_LSB + IDX_W;

  logic              rst_sync_n;
  logic              hit;
  reg_idx_e          idx;
  logic              wr_stat, wr_ctrl, wr_per;
  logic [DATA_W-1:0] ctrl_q, period_q, cnt_q;
  logic              to_q, run_q, expire;

  itmr_rst_sync u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  assign hit = (bus_addr[ADDR_W-1:HIGH_LSB] == '0);
  assign idx = reg_idx_e'(bus_addr[HIGH_LSB-1:IDX_LSB]);

  assign wr_stat = bus_sel && bus_we && hit && (idx == IDX_STAT);
  assign wr_ctrl = bus_sel && bus_we && hit && (idx == IDX_CTRL);
  assign wr_per  = bus_sel && bus_we && hit && (idx == IDX_PER);

  itmr_regs #(.DATA_W(DATA_W)) u_regs (
    .clk      (clk),
    .rst_n    (rst_sync_n),
    .wr_stat  (wr_stat),
    .wr_ctrl  (wr_ctrl),
    .wr_per   (wr_per),
    .wdata    (bus_wdata),
    .expire   (expire),
    .ctrl_q   (ctrl_q),
    .period_q (period_q),
    .to_q     (to_q),
    .run_q    (run_q)
  );

  itmr_count #(.DATA_W(DATA_W)) u_count (
    .clk      (clk),
    .rst_n    (rst_sync_n),
    .run      (run_q),
    .cont     (ctrl_q[CTL_CONT]),
    .load_en  (wr_per),
    .load_val (bus_wdata),
    .period   (period_q),
    .count    (cnt_q),
    .expire   (expire)
  );

  always_comb begin
    bus_rdata = '0;
    if (bus_sel && !bus_we && hit) begin
      unique case (idx)
        IDX_STAT: begin
          bus_rdata[STS_TO]  = to_q;
          bus_rdata[STS_RUN] = run_q;
        end
        IDX_CTRL: bus_rdata = ctrl_q;
        IDX_PER:  bus_rdata = period_q;
        IDX_SNAP: bus_rdata = cnt_q;
        default:  bus_rdata = '0;
      endcase
    end
  end

  assign irq = to_q & ctrl_q[CTL_IE];

endmodule

// File: rtl/interval_timer_chk.sv
module interval_timer_chk
  import interval_timer_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input logic              clk,
  input logic              rst_sync_n,
  input logic              wr_stat,
  input logic              wr_ctrl,
  input logic              wr_per,
  input logic [DATA_W-1:0] bus_wdata,
  input logic [DATA_W-1:0] cnt_q,
  input logic              run_q,
  input logic              to_q,
  input logic              expire,
  input logic [DATA_W-1:0] ctrl_q
);

  AST_STOP_WINS: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (wr_ctrl && bus_wdata[CTL_STOP]) |=> !run_q); // R4

  AST_PERIOD_LOAD: assert property (@(posedge clk) disable iff (!rst_sync_n)
    wr_per |=> (cnt_q == $past(bus_wdata))); // R5

  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (!run_q && !wr_per) |=> $stable(cnt_q)); // R5

  AST_STEP_DOWN: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (run_q && !expire && !wr_per) |=> (cnt_q == $past(cnt_q) - 1'b1)); // R6

  AST_ONESHOT_END: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (expire && !ctrl_q[CTL_CONT] && !wr_ctrl && !wr_per) |=> (!run_q && cnt_q == '0)); // R7

  AST_ACK_CLEARS: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (wr_stat && !expire) |=> !to_q); // R9

  AST_EXPIRY_WINS: assert property (@(posedge clk) disable iff (!rst_sync_n)
    expire |=> to_q); // R12

endmodule

bind interval_timer interval_timer_chk #(.DATA_W(DATA_W)) u_chk (
  .clk        (clk),
  .rst_sync_n (rst_sync_n),
  .wr_stat    (wr_stat),
  .wr_ctrl    (wr_ctrl),
  .wr_per     (wr_per),
  .bus_wdata  (bus_wdata),
  .cnt_q      (cnt_q),
  .run_q      (run_q),
  .to_q       (to_q),
  .expire     (expire),
  .ctrl_q     (ctrl_q)
);

// File: tb/test_interval_timer.sv
`timescale 1ns/1ps
module test_interval_timer;

  localparam int DW = 32;
  localparam int AW = 5;
  localparam logic [AW-1:0] A_STAT = 5'h00, A_CTRL = 5'h04, A_PER = 5'h08,
                            A_SNAP = 5'h0C, A_NONE = 5'h10;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          bus_sel = 1'b0;
  logic          bus_we = 1'b0;
  logic [AW-1:0] bus_addr = '0;
  logic [DW-1:0] bus_wdata = '0;
  logic [DW-1:0] bus_rdata;
  logic          irq;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  interval_timer #(.DATA_W(DW), .ADDR_W(AW)) i_interval_timer (
    .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_we(bus_we),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq(irq)
  );

  task automatic expect_eq(input string req, input logic [DW-1:0] act, input logic [DW-1:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=0x%08h expected=0x%08h", req, act, exp);
    end
  endtask

  // called at a falling edge; the write lands on the next rising edge
  task automatic wr(input logic [AW-1:0] a, input logic [DW-1:0] d);
    bus_sel = 1'b1; bus_we = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_sel = 1'b0; bus_we = 1'b0; bus_wdata = '0;
  endtask

  task automatic rd(input logic [AW-1:0] a, output logic [DW-1:0] d);
    bus_sel = 1'b1; bus_we = 1'b0; bus_addr = a;
    #1 d = bus_rdata;
    bus_sel = 1'b0;
  endtask

  task automatic check_rd(input string req, input logic [AW-1:0] a, input logic [DW-1:0] exp);
    logic [DW-1:0] v;
    rd(a, v);
    expect_eq(req, v, exp);
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    idle(3);
    rst_n = 1'b1;
    idle(3);
  endtask

  task automatic t_reset_state();
    check_rd("R1 status", A_STAT, 32'h0);
    check_rd("R1 control", A_CTRL, 32'h0);
    check_rd("R1 period", A_PER, 32'h0);
    check_rd("R1 snapshot", A_SNAP, 32'h0);
    expect_eq("R1 irq", {31'b0, irq}, 32'h0);
  endtask

  task automatic t_period_load();
    wr(A_PER, 32'd10);
    check_rd("R5 period readback", A_PER, 32'd10);
    check_rd("R5 immediate load", A_SNAP, 32'd10);
    idle(3);
    check_rd("R5 stopped holds", A_SNAP, 32'd10);
    check_rd("R5 not running", A_STAT, 32'h0);
  endtask

  task automatic t_one_shot();
    wr(A_PER, 32'd5);
    wr(A_CTRL, 32'h5);
    check_rd("R3 start sets running", A_STAT, 32'h2);
    check_rd("R3 control readback", A_CTRL, 32'h5);
    idle(4);
    check_rd("R6 count one before expiry", A_SNAP, 32'd1);
    check_rd("R6 no flag yet", A_STAT, 32'h2);
    idle(1);
    check_rd("R6 R7 flag set, stopped", A_STAT, 32'h1);
    check_rd("R7 count zero", A_SNAP, 32'd0);
    expect_eq("R10 irq high", {31'b0, irq}, 32'h1);
    idle(2);
    check_rd("R7 stays zero", A_SNAP, 32'd0);
    wr(A_STAT, 32'hFFFF_FFFF);
    check_rd("R9 ack all-ones", A_STAT, 32'h0);
    expect_eq("R10 irq low after ack", {31'b0, irq}, 32'h0);
  endtask

  task automatic t_continuous();
    wr(A_PER, 32'd4);
    wr(A_CTRL, 32'h7);
    idle(3);
    check_rd("R8 first count one", A_SNAP, 32'd1);
    idle(1);
    check_rd("R8 flag and running", A_STAT, 32'h3);
    check_rd("R8 reloaded", A_SNAP, 32'd4);
    wr(A_STAT, 32'h0);
    check_rd("R9 ack zero data", A_STAT, 32'h2);
    idle(2);
    check_rd("R8 second count one", A_SNAP, 32'd1);
    idle(1);
    check_rd("R8 second expiry", A_STAT, 32'h3);
    wr(A_CTRL, 32'h8);
    check_rd("R4 stop clears running", A_STAT, 32'h1);
    check_rd("R4 frozen count", A_SNAP, 32'd3);
    expect_eq("R10 irq masked", {31'b0, irq}, 32'h0);
    idle(3);
    check_rd("R4 still frozen", A_SNAP, 32'd3);
    wr(A_CTRL, 32'h1);
    expect_eq("R10 irq on enable", {31'b0, irq}, 32'h1);
    wr(A_STAT, 32'h0);
  endtask

  task automatic t_start_stop_both();
    wr(A_PER, 32'd6);
    wr(A_CTRL, 32'hC);
    idle(3);
    check_rd("R4 both bits: stopped", A_STAT, 32'h0);
    check_rd("R4 both bits: count held", A_SNAP, 32'd6);
    check_rd("R3 stored strobes", A_CTRL, 32'hC);
  endtask

  task automatic t_ignored_writes();
    wr(A_SNAP, 32'h0000_ABCD);
    check_rd("R11 snapshot unchanged", A_SNAP, 32'd6);
    check_rd("R11 period unchanged", A_PER, 32'd6);
    wr(A_NONE, 32'h55);
    check_rd("R2 unmapped write ctrl", A_CTRL, 32'hC);
    check_rd("R2 unmapped write period", A_PER, 32'd6);
    check_rd("R2 unmapped read", A_NONE, 32'h0);
  endtask

  task automatic t_ack_race();
    wr(A_PER, 32'd3);
    wr(A_CTRL, 32'h4);
    idle(2);
    wr(A_STAT, 32'h0);
    check_rd("R12 expiry beats ack", A_STAT, 32'h1);
    wr(A_STAT, 32'h0);
    check_rd("R9 later ack clears", A_STAT, 32'h0);
  endtask

  task automatic t_reset_midrun();
    wr(A_PER, 32'd100);
    wr(A_CTRL, 32'h7);
    idle(5);
    rst_n = 1'b0;
    #1;
    check_rd("R1 async status", A_STAT, 32'h0);
    check_rd("R1 async period", A_PER, 32'h0);
    check_rd("R1 async snapshot", A_SNAP, 32'h0);
    expect_eq("R1 async irq", {31'b0, irq}, 32'h0);
    idle(2);
    rst_n = 1'b1;
    idle(3);
    check_rd("R1 control after reset", A_CTRL, 32'h0);
  endtask

  initial begin
    rst_n = 1'b0;
    idle(3);
    t_reset_state();
    rst_n = 1'b1;
    idle(3);
    t_reset_state();
    t_period_load();
    t_one_shot();
    t_continuous();
    t_start_stop_both();
    t_ignored_writes();
    t_ack_race();
    t_reset_midrun();
    do_reset();
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

endmodule